// File: doc/BRIEF.md
# Leaf Page Entry Access Judge

This block decides whether one memory access may use a leaf page-table entry that a translation walker has just fetched. The walker drives the low control bits of the leaf entry together with three request qualifiers: whether the requester runs privileged, whether the access is a store, and whether it is an instruction fetch. It then pulses a check strobe. One clock later the block returns a one-cycle valid pulse carrying exactly one of three verdicts: grant, permission fault or reference/change fault. The walker uses the grant to go on and fill its translation buffer, and either fault to end the walk.

The verdict covers three things. The first is the four-bit access-authority field, which holds privileged-only, read, read/write and execute bits. The second is a cache-inhibit override that refuses execution from I/O-attributed pages. The third is the gating on the Reference and Change bits. A permission fault always wins over a reference/change fault, so the walker never sees both at once. The walker slices bits 8:0 of the entry onto the control-bit port. The block does not use the higher bits of the entry, which hold the page number and the valid and leaf markers.

Top module: `pte_access_judge`

## Requirements
- R1: While `rst` is high, and on the cycle after a clock edge with `rst` high, `res_valid`, `res_ok`, `res_perm_fault` and `res_rc_fault` are all 0. Reset wins over a strobe sampled at the same edge.
- R2: A strobe sampled on a clock edge makes `res_valid` high for the cycle after that edge only. Without a strobe, `res_valid` and all three verdict flags are 0. Strobes on consecutive edges give results on consecutive cycles, each belonging to its own request.
- R3: Whenever `res_valid` is high, exactly one of `res_ok`, `res_perm_fault` and `res_rc_fault` is high.
- R4: Entry bit 3 marks a page as privileged-only. A request with `req_priv` = 0 to such a page always gets a permission fault. A privileged request is judged on the other bits.
- R5: For a data load (`req_fetch` = 0, `req_store` = 0), permission passes if entry bit 2 (read) or bit 1 (read/write) is set.
- R6: For a data store (`req_fetch` = 0, `req_store` = 1), permission passes only if entry bit 1 is set. Bit 2 alone fails.
- R7: For an instruction fetch (`req_fetch` = 1), permission passes only if entry bit 0 (execute) is set and entry bit 5 is clear.
- R8: Entry bits 5:4 hold the memory attribute: 00 normal, 10 non-idempotent I/O, 11 tolerant I/O. A fetch from either I/O encoding is refused even when execute is granted. Data accesses to those pages are not affected by the attribute.
- R9: The reference/change check passes when entry bit 8 (Reference) is set and, for any access with `req_store` = 1, entry bit 7 (Change) is also set.
- R10: When permission fails, the verdict is a permission fault whatever the reference/change state. A reference/change fault is reported only when permission passed.
- R11: For a fetch, the read bits (2 and 1) have no effect on permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chk_req | input | 1 | Check strobe, one cycle per request |
| pte_ctl_bits | input | 9 | Bits 8:0 of the leaf entry |
| req_priv | input | 1 | Requester is privileged |
| req_store | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| res_valid | output | 1 | Verdict valid, one cycle after the strobe |
| res_ok | output | 1 | Access granted |
| res_perm_fault | output | 1 | Permission fault |
| res_rc_fault | output | 1 | Reference/change fault |

## Verification
The stimulus table drives loads, stores and fetches against entries built so that each authority bit is the only thing deciding the verdict. This separates read from read/write for stores, execute from the read bits for fetches, and privileged from unprivileged access to privileged-only pages. Fetches from each attribute encoding show the cache-inhibit override apart from the execute bit. Entries that lack Reference, lack Change, or fail both checks at once show the reference/change gating and the precedence of the permission fault. Directed sequences cover back-to-back strobes, idle cycles and a strobe that meets reset, which exercises the one-cycle pulse timing.

// File: rtl/pte_judge_pkg.sv
package pte_judge_pkg;

  // Bit positions inside the leaf entry (little-endian numbering)
  localparam int BIT_EXEC     = 0;
  localparam int BIT_RW       = 1;
  localparam int BIT_RD       = 2;
  localparam int BIT_PRIVONLY = 3;
  localparam int BIT_ATTR_LO  = 4;
  localparam int BIT_ATTR_HI  = 5;
  localparam int BIT_CHG      = 7;
  localparam int BIT_REF      = 8;
  localparam int CTL_W        = BIT_REF + 1;

  typedef enum logic [1:0] {
    ATTR_NORMAL   = 2'b00,
    ATTR_RSVD     = 2'b01,
    ATTR_NONIDEM  = 2'b10,
    ATTR_TOLERANT = 2'b11
  } attr_e;

  typedef struct packed {
    logic  exec;
    logic  rw;
    logic  rd;
    logic  priv_only;
    attr_e attr;
    logic  chg;
    logic  refd;
  } pte_fields_t;

  typedef struct packed {
    logic priv;
    logic store;
    logic fetch;
  } access_t;

  typedef struct packed {
    logic ok;
    logic perm_fault;
    logic rc_fault;
  } verdict_t;

endpackage

// File: rtl/pte_field_split.sv
module pte_field_split
  import pte_judge_pkg::*;
#(
  parameter int W = CTL_W
) (
  input  logic [W-1:0] ctl_bits,
  output pte_fields_t  fields,
  output logic         cache_inhibit
);
  always_comb begin
    fields.exec      = ctl_bits[BIT_EXEC];
    fields.rw        = ctl_bits[BIT_RW];
    fields.rd        = ctl_bits[BIT_RD];
    fields.priv_only = ctl_bits[BIT_PRIVONLY];
    fields.attr      = attr_e'(ctl_bits[BIT_ATTR_HI:BIT_ATTR_LO]);
    fields.chg       = ctl_bits[BIT_CHG];
    fields.refd      = ctl_bits[BIT_REF];
  end

  // Both I/O encodings carry the inhibit bit
  always_comb begin
    unique case (fields.attr)
      ATTR_NONIDEM, ATTR_TOLERANT: cache_inhibit = 1'b1;
      default:                     cache_inhibit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pte_perm_eval.sv
module pte_perm_eval
  import pte_judge_pkg::*;
(
  input  pte_fields_t fields,
  input  logic        cache_inhibit,
  input  access_t     acc,
  output logic        perm_ok
);
  logic gate_open;
  logic data_ok;
  logic fetch_ok;

  assign gate_open = acc.priv | ~fields.priv_only;
  assign data_ok   = fields.rw | (fields.rd & ~acc.store);
  assign fetch_ok  = fields.exec & ~cache_inhibit;
  assign perm_ok   = gate_open & (acc.fetch ? fetch_ok : data_ok);
endmodule

// File: rtl/pte_rc_eval.sv
module pte_rc_eval
  import pte_judge_pkg::*;
(
  input  pte_fields_t fields,
  input  access_t     acc,
  output logic        rc_ok
);
  assign rc_ok = fields.refd & (fields.chg | ~acc.store);
endmodule

// File: rtl/pte_access_judge.sv
module pte_access_judge
  import pte_judge_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             chk_req,
  input  logic [CTL_W-1:0] pte_ctl_bits,
  input  logic             req_priv,
  input  logic             req_store,
  input  logic             req_fetch,
  output logic             res_valid,
  output logic             res_ok,
  output logic             res_perm_fault,
  output logic             res_rc_fault
);
  pte_fields_t fields;
  logic        cache_inhibit;
  access_t     acc;
  logic        perm_ok;
  logic        rc_ok;
  verdict_t    next_v;
  verdict_t    held_v;
  logic        valid_q;

  assign acc = '{priv: req_priv, store: req_store, fetch: req_fetch};

  pte_field_split #(.W(CTL_W)) u_split (
    .ctl_bits      (pte_ctl_bits),
    .fields        (fields),
    .cache_inhibit (cache_inhibit)
  );

  pte_perm_eval u_perm (
    .fields        (fields),
    .cache_inhibit (cache_inhibit),
    .acc           (acc),
    .perm_ok       (perm_ok)
  );

  pte_rc_eval u_rc (
    .fields (fields),
    .acc    (acc),
    .rc_ok  (rc_ok)
  );

  // Permission failure overrides reference/change failure
  always_comb begin
    next_v.ok         = perm_ok & rc_ok;
    next_v.perm_fault = ~perm_ok;
    next_v.rc_fault   = perm_ok & ~rc_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      held_v  <= '0;
    end else begin
      valid_q <= chk_req;
      held_v  <= chk_req ? next_v : '0;
    end
  end

  assign res_valid      = valid_q;
  assign res_ok         = held_v.ok;
  assign res_perm_fault = held_v.perm_fault;
  assign res_rc_fault   = held_v.rc_fault;

  a_r2_pulse_follows: assert property (@(posedge clk) disable iff (rst)
    chk_req |=> res_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $past(chk_req));
  a_r3_one_verdict: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $countones({res_ok, res_perm_fault, res_rc_fault}) == 1);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !(res_ok || res_perm_fault || res_rc_fault));
  a_r4_privonly_fault: assert property (@(posedge clk) disable iff (rst)
    (chk_req && !req_priv && pte_ctl_bits[BIT_PRIVONLY]) |=> res_perm_fault);
  a_r8_ci_fetch_denied: assert property (@(posedge clk) disable iff (rst)
    (chk_req && req_fetch && pte_ctl_bits[BIT_ATTR_HI]) |=> !res_ok);
  a_r9_ref_required: assert property (@(posedge clk) disable iff (rst)
    (chk_req && !pte_ctl_bits[BIT_REF]) |=> !res_ok);
  a_r10_perm_first: assert property (@(posedge clk) disable iff (rst)
    res_perm_fault |-> !res_rc_fault);
endmodule

// File: tb/pte_access_judge_bench.sv
module pte_access_judge_bench;
  typedef struct packed {
    logic [8:0] bits;
    logic       priv;
    logic       store;
    logic       fetch;
    logic [2:0] expv;   // {ok, perm_fault, rc_fault}
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{9'h104, 1'b0, 1'b0, 1'b0, 3'b100},  // R5 load with read only
    '{9'h102, 1'b0, 1'b0, 1'b0, 3'b100},  // R5 load with read/write
    '{9'h000 | 9'h100, 1'b0, 1'b0, 1'b0, 3'b010},  // R5 no read bits
    '{9'h184, 1'b0, 1'b1, 1'b0, 3'b010},  // R6 store with read only
    '{9'h182, 1'b0, 1'b1, 1'b0, 3'b100},  // R6 store with read/write
    '{9'h10A, 1'b0, 1'b0, 1'b0, 3'b010},  // R4 unprivileged, priv-only page
    '{9'h10A, 1'b1, 1'b0, 1'b0, 3'b100},  // R4 privileged, priv-only page
    '{9'h101, 1'b1, 1'b0, 1'b1, 3'b100},  // R7 fetch, execute, normal
    '{9'h121, 1'b1, 1'b0, 1'b1, 3'b010},  // R8 fetch, non-idempotent
    '{9'h131, 1'b1, 1'b0, 1'b1, 3'b010},  // R8 fetch, tolerant I/O
    '{9'h134, 1'b0, 1'b0, 1'b0, 3'b100},  // R8 load from tolerant I/O
    '{9'h106, 1'b1, 1'b0, 1'b1, 3'b010},  // R11 fetch, read bits only
    '{9'h004, 1'b0, 1'b0, 1'b0, 3'b001},  // R9 no reference bit
    '{9'h102, 1'b0, 1'b1, 1'b0, 3'b001},  // R9 store, no change bit
    '{9'h002, 1'b0, 1'b1, 1'b0, 3'b001},  // R9 store, neither bit
    '{9'h004, 1'b0, 1'b1, 1'b0, 3'b010},  // R10 both checks fail
    '{9'h101, 1'b1, 1'b1, 1'b1, 3'b001}   // R9 store flag gates change on fetch
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       chk_req = 1'b0;
  logic [8:0] pte_ctl_bits = '0;
  logic       req_priv = 1'b0;
  logic       req_store = 1'b0;
  logic       req_fetch = 1'b0;
  logic       res_valid, res_ok, res_perm_fault, res_rc_fault;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pte_access_judge u_pte_access_judge (
    .clk, .rst, .chk_req, .pte_ctl_bits, .req_priv, .req_store, .req_fetch,
    .res_valid, .res_ok, .res_perm_fault, .res_rc_fault
  );

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {valid,ok,perm,rc} actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {res_valid, res_ok, res_perm_fault, res_rc_fault};
  endfunction

  task automatic drive(input vec_t v);
    pte_ctl_bits = v.bits;
    req_priv     = v.priv;
    req_store    = v.store;
    req_fetch    = v.fetch;
    chk_req      = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset state", outs(), 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    check("R2 idle after reset", outs(), 4'b0000);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R3 vector %0d", i), outs(), {1'b1, VECS[i].expv});
      chk_req = 1'b0;
      @(negedge clk);
      check($sformatf("R2 pulse ends after vector %0d", i), outs(), 4'b0000);
    end

    // R2 back-to-back strobes
    drive(VECS[0]);
    @(negedge clk);
    check("R2 back-to-back first", outs(), {1'b1, VECS[0].expv});
    drive(VECS[13]);
    @(negedge clk);
    check("R2 back-to-back second", outs(), {1'b1, VECS[13].expv});
    chk_req = 1'b0;
    @(negedge clk);
    check("R2 back-to-back end", outs(), 4'b0000);

    // R2 inputs change without strobe: nothing appears
    pte_ctl_bits = 9'h1FF;
    req_priv = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 no strobe no verdict", outs(), 4'b0000);

    // R1 reset beats a strobe at the same edge
    drive(VECS[1]);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset over strobe", outs(), 4'b0000);
    chk_req = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1 quiet after reset release", outs(), 4'b0000);
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 2000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule